// File: doc/BRIEF.md
# Write-Only Serial Control Register Target

This block is a two-wire serial bus target that accepts write transfers only. It owns a bank of 26 byte-wide control registers at indices 00h to 19h, each brought out in parallel to the LED control logic that sits next to it. The bus lines arrive as plain digital samples. They pass through a two-flop synchronizer into the system clock domain, and all bus events are derived from the synchronized levels. The acknowledge goes out as an open-drain pull-down request.

A transfer opens with a START, carries the target's 7-bit device address with a write flag, then a register index byte, then any number of data bytes. The first data byte lands at the index. Each following byte lands at the next index. Bytes aimed past the last register are acknowledged and then dropped. A read request or a foreign address is left unacknowledged, and the target ignores the bus until the next START or STOP. A repeated START at any point begins address reception again.

Top module: `ctl_i2c_wr_target`

## Requirements
- R1: While rst_ni is low, every register reads 00h on regs_o and sda_pull_o is 0.
- R2: An address byte equal to 1110101 followed by a 0 direction bit (first byte EAh, MSB first) is acknowledged on the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. The data and index bytes that follow it are neither acknowledged nor written until a new START.
- R4: An address byte of 1110101 with direction bit 1 (EBh) is not acknowledged, and the following bytes are ignored.
- R5: The second byte sets the register index and is acknowledged. The third byte is acknowledged and appears on regs_o bits [8*index+7 : 8*index].
- R6: Each further data byte in the same transfer is written to the next higher index.
- R7: A data byte whose index is 1Ah or above is acknowledged, and no register changes.
- R8: The target pulls SDA low only from the eighth SCL falling edge of an acknowledged byte to the following ninth falling edge. At all other times it releases SDA.
- R9: A repeated START in the middle of a transfer discards the partial transfer and starts address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level, asynchronous |
| sda_i | input | 1 | Serial data line level, asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| regs_o | output | 208 | Register bank, register n at bits [8n+7:8n] |

## Verification
A pointer that is off by one, or that fails to advance, shows up as a byte in the wrong lane of regs_o. That difference is visible about four system clocks after the eighth SCL fall of the affected data byte. A wrong protocol state shows up on the ninth clock of the next byte, as an acknowledge that is missing or one that should not be there. It also appears as a write that lands after a rejected address. A late or stuck acknowledge release leaves SDA low into the next byte's first bit, so the release is checked on the SCL low phase that follows.

// File: rtl/ctl_i2c_wr_pkg.sv
package ctl_i2c_wr_pkg;
  localparam logic [6:0] DEV_ADDR = 7'b1110101;
  localparam int unsigned NUM_REGS = 26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_DATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // idle bus level is high
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl_i2c_events.sv
module ctl_i2c_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA moves with SCL held high: bus conditions only
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/ctl_i2c_fsm.sv
module ctl_i2c_fsm
  import ctl_i2c_wr_pkg::*;
#(
  parameter logic [6:0]  ADDR  = DEV_ADDR,
  parameter int unsigned NREGS = NUM_REGS,
  parameter int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  output logic          ack_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          skip_o
);
  localparam logic [7:0] LIMIT    = 8'(NREGS);
  localparam logic [7:0] ADDR_BYT = {ADDR, 1'b0};

  bus_state_e state_q;
  logic [3:0] bit_cnt_q;
  logic       in_ack_q;
  logic [7:0] shift_q;
  logic [7:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      shift_q   <= '0;
      ptr_q     <= '0;
      ack_o     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        ack_o     <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        ack_o     <= 1'b0;
      end else if (state_q inside {ST_DEV, ST_PTR, ST_DATA}) begin
        if (scl_rise_i && bit_cnt_q < 4'd8) begin
          shift_q   <= {shift_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
          if (!in_ack_q) begin
            // eighth fall: byte complete
            in_ack_q <= 1'b1;
            unique case (state_q)
              ST_DEV: begin
                if (shift_q == ADDR_BYT) ack_o <= 1'b1;
                else state_q <= ST_SKIP;
              end
              ST_PTR: begin
                ptr_q <= shift_q;
                ack_o <= 1'b1;
              end
              default: begin
                ack_o     <= 1'b1;
                wr_en_o   <= (ptr_q < LIMIT);
                wr_addr_o <= ptr_q[AW-1:0];
                wr_data_o <= shift_q;
                if (ptr_q != 8'hFF) ptr_q <= ptr_q + 8'd1;
              end
            endcase
          end else begin
            // ninth fall: release and advance
            in_ack_q  <= 1'b0;
            ack_o     <= 1'b0;
            bit_cnt_q <= '0;
            if (state_q == ST_DEV) state_q <= ST_PTR;
            else if (state_q == ST_PTR) state_q <= ST_DATA;
          end
        end
      end
    end
  end

  assign skip_o = (state_q == ST_SKIP);
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank #(
  parameter int unsigned NREGS = 26,
  parameter int unsigned AW    = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic [NREGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[i*8 +: 8] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i)) regs_o[i*8 +: 8] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ctl_i2c_wr_target.sv
module ctl_i2c_wr_target
  import ctl_i2c_wr_pkg::*;
#(
  parameter logic [6:0]  ADDR  = DEV_ADDR,
  parameter int unsigned NREGS = NUM_REGS,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREGS*8-1:0] regs_o
);
  logic          scl_s, sda_s;
  logic          start, stop, scl_rise, scl_fall;
  logic          wr_en, skip;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  ctl_i2c_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  ctl_i2c_events u_events (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  ctl_i2c_fsm #(.ADDR(ADDR), .NREGS(NREGS), .AW(AW)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .ack_o(sda_pull_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .skip_o(skip)
  );

  ctl_i2c_regbank #(.NREGS(NREGS), .AW(AW)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .regs_o
  );
endmodule

// File: rtl/ctl_i2c_wr_target_chk.sv
module ctl_i2c_wr_target_chk #(
  parameter int unsigned NREGS = 26,
  parameter int unsigned AW    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s_i,
  input logic               sda_pull_i,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [7:0]         wr_data_i,
  input logic               skip_i,
  input logic [NREGS*8-1:0] regs_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear : assert (regs_i == '0 && !sda_pull_i)
        else $error("R1: outputs not cleared in reset");
    end
  end

  a_r8_ack_rise_scl_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> !scl_s_i);

  a_r8_ack_fall_scl_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_i) |-> !scl_s_i);

  a_r4_no_ack_when_skipping : assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i |-> !sda_pull_i);

  a_r3_skip_holds_regs : assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i |=> $stable(regs_i));

  a_r7_write_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (32'(wr_addr_i) < NREGS));

  a_r5_write_lands : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_i[$past(wr_addr_i)*8 +: 8] == $past(wr_data_i));
endmodule

bind ctl_i2c_wr_target ctl_i2c_wr_target_chk #(.NREGS(NREGS), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_pull_i(sda_pull_o),
  .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
  .skip_i(skip), .regs_i(regs_o)
);

// File: tb/ctl_i2c_wr_target_bench.sv
`timescale 1ns/1ps
module ctl_i2c_wr_target_bench;
  localparam int NREGS = 26;
  localparam int TQ    = 16;
  localparam logic [7:0] AW_BYTE = 8'hEA;
  localparam logic [7:0] AR_BYTE = 8'hEB;
  // {index, data}
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h015A, 16'h0C3F,
                                      16'h19FF, 16'h0880, 16'h1301};

  logic clk = 0, rst_ni = 0, scl = 1, sda_drv = 1;
  logic sda_pull;
  logic [NREGS*8-1:0] regs;
  logic sda_line;
  logic [7:0] model [NREGS];
  int errors = 0, checks = 0;
  logic ack;

  assign sda_line = sda_drv & ~sda_pull;
  always #5 clk = ~clk;

  ctl_i2c_wr_target u_ctl_i2c_wr_target (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bank(string req);
    logic [NREGS*8-1:0] e;
    for (int i = 0; i < NREGS; i++) e[i*8 +: 8] = model[i];
    checks++;
    if (regs !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, regs, e);
    end
  endtask

  task automatic wq(); repeat (TQ) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1; wq(); scl = 1; wq(); sda_drv = 0; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    scl = 0; sda_drv = 0; wq(); scl = 1; wq(); sda_drv = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    sda_drv = 1; wq(); scl = 1; wq();
    got_ack = ~sda_line;
    wq(); scl = 0; wq();
  endtask

  task automatic clear_model();
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_model();
    repeat (5) @(negedge clk);
    chk("R1 reset regs", 32'(regs == '0), 32'd1);
    chk("R1 reset pull", 32'(sda_pull), 32'd0);
    rst_ni = 1;
    repeat (5) @(negedge clk);

    // table walk: single writes
    foreach (VEC[k]) begin
      bus_start();
      send_byte(AW_BYTE, ack);
      chk("R2 address ack", 32'(ack), 32'd1);
      send_byte(VEC[k][15:8], ack);
      chk("R5 index ack", 32'(ack), 32'd1);
      send_byte(VEC[k][7:0], ack);
      chk("R5 data ack", 32'(ack), 32'd1);
      chk("R8 released after ninth fall", 32'(sda_pull), 32'd0);
      bus_stop();
      model[VEC[k][15:8]] = VEC[k][7:0];
      chk_bank("R5 table write");
    end

    // R6 burst into the top, R7 overflow discarded
    bus_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h17, ack);
    send_byte(8'hA1, ack); chk("R6 burst ack 0", 32'(ack), 32'd1);
    send_byte(8'hA2, ack); chk("R6 burst ack 1", 32'(ack), 32'd1);
    send_byte(8'hA3, ack); chk("R6 burst ack 2", 32'(ack), 32'd1);
    send_byte(8'hA4, ack); chk("R7 past-end ack", 32'(ack), 32'd1);
    bus_stop();
    model[8'h17] = 8'hA1; model[8'h18] = 8'hA2; model[8'h19] = 8'hA3;
    chk_bank("R6 R7 burst bank");

    // R7 index far beyond end
    bus_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h1F, ack);
    send_byte(8'h66, ack); chk("R7 out-of-range ack", 32'(ack), 32'd1);
    bus_stop();
    chk_bank("R7 out-of-range no change");

    // R3 foreign address
    bus_start();
    send_byte(8'hE8, ack); chk("R3 foreign nack", 32'(ack), 32'd0);
    send_byte(8'h02, ack); chk("R3 following nack", 32'(ack), 32'd0);
    send_byte(8'h77, ack); chk("R3 data nack", 32'(ack), 32'd0);
    bus_stop();
    chk_bank("R3 no write");

    // R4 read request
    bus_start();
    send_byte(AR_BYTE, ack); chk("R4 read nack", 32'(ack), 32'd0);
    send_byte(8'h03, ack);
    send_byte(8'h55, ack); chk("R4 following nack", 32'(ack), 32'd0);
    bus_stop();
    chk_bank("R4 no write");

    // R9 repeated start mid transfer
    bus_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte(AW_BYTE, ack); chk("R9 re-address ack", 32'(ack), 32'd1);
    send_byte(8'h06, ack);
    send_byte(8'h11, ack);
    bus_stop();
    model[6] = 8'h11;
    chk_bank("R9 restarted write");

    // R9 repeated start rescues a skipped transfer
    bus_start();
    send_byte(8'h20, ack);
    bus_start();
    send_byte(AW_BYTE, ack); chk("R9 after skip ack", 32'(ack), 32'd1);
    send_byte(8'h02, ack);
    send_byte(8'hC4, ack);
    bus_stop();
    model[2] = 8'hC4;
    chk_bank("R9 after skip write");

    // R1 reset mid run
    @(negedge clk); rst_ni = 0;
    repeat (3) @(negedge clk);
    clear_model();
    chk_bank("R1 reset clears bank");
    chk("R1 reset pull low-free", 32'(sda_pull), 32'd0);
    rst_ni = 1;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule